// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block models a byte-wide static RAM in which every word has a nonvolatile shadow word. It also holds the control logic that moves the whole array between the two copies in one parallel step. The host sees a clocked version of an asynchronous SRAM port. It has an active-low chip enable, output enable and write enable, an address, and a data path split into an input bus, an output bus and an output-enable flag. Besides the host port there are a power-good input, an active-low hardware store request, and a busy output. The busy output pulls the shared store/busy line low.

In normal operation the port behaves like a plain SRAM, and the shadow copy is left alone. A full-array STORE (SRAM to shadow) starts in one of three ways: the store line is pulled low, the host reads a fixed chain of six addresses, or power is lost. A RECALL (shadow to SRAM) starts at power-up, or when the host reads a second chain of six addresses. A RECALL first clears the SRAM and then loads it from the shadow. While a transfer runs, the port is locked out. The long transfer times of a real part are scaled down to parameter cycle counts, and a STORE takes much longer than a RECALL.

The host port is a memory port, not a stream. It has no valid/ready handshake and no back-pressure. The host learns that a transfer is running only from the busy output. During that time, accesses are dropped without notice. The default geometry is 64 words. Setting `ADDR_W` to 15 gives the full 32K x 8 array.

Top module: `nvsram_top`

## Requirements
- R1: A cycle with `ce_n`=0, `we_n`=1 and `oe_n`=0, taken while the port is enabled, is an output read. In the next cycle `dq_oe`=1 and `dq_out` holds the SRAM word at `addr`.
- R2: A cycle with `ce_n`=0 and `we_n`=0, taken while the port is enabled, writes `dq_in` to the SRAM word at `addr`, whatever `oe_n` is. In the next cycle `dq_oe`=0.
- R3: After a standby cycle (`ce_n`=1) or an internal read (`ce_n`=0, `we_n`=1, `oe_n`=1), `dq_oe` is 0 in the next cycle.
- R4: If `hw_store_n` is sampled low while the block is idle, `busy_pull_low` is 1 from the next cycle for exactly `STORE_CYC` cycles. After that, the shadow holds the SRAM contents and the SRAM is unchanged.
- R5: While `busy_pull_low` is 1, `dq_oe` stays 0 and writes are discarded.
- R6: The software sequence is six reads in a row: `SEQ_A0`, `SEQ_A1`, `SEQ_A2`, `SEQ_A3`, `SEQ_A4`, then `STORE_A` to start a STORE or `RECALL_A` to start a RECALL. The final read of the chain drives no data (`dq_oe`=0), and the transfer begins in the next cycle.
- R7: A write, or a read of an address out of order, breaks the chain. If that read is of `SEQ_A0`, it counts as the first step of a new chain. Standby cycles do not break the chain.
- R8: A RECALL holds `busy_pull_low` at 1 for `RECALL_CYC`+1 cycles. After it, every SRAM word equals its shadow word. A RECALL never changes the shadow, so repeated recalls return the same data.
- R9: If `power_ok` is sampled low while the block is idle, a STORE of `STORE_CYC` cycles runs. After it, the port is disabled (`dq_oe`=0, `busy_pull_low`=0) until `power_ok` returns high. A power-up RECALL then runs automatically.
- R10: Reset clears `dq_oe` and `busy_pull_low` and zeroes the shadow. Until `power_ok` is high and the power-up RECALL has finished, the port is disabled. After that, every word reads 0.
- R11: SRAM writes never change the shadow. A RECALL after writes brings back the data from the last STORE.
- R12: When several STORE or RECALL starts are requested in the same idle cycle, the order is: power loss first, then the hardware store line, then the software chain. A hardware store that coincides with a final RECALL read therefore runs as a STORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low model reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | Read data is driven (otherwise high-Z) |
| power_ok | input | 1 | Supply is good |
| hw_store_n | input | 1 | Level seen on the shared store/busy line, low requests a STORE |
| busy_pull_low | output | 1 | Pulls the store/busy line low while a transfer runs |

## Verification
Read data and the `dq_oe` flag are due one cycle after the access cycle. Busy rises one cycle after a STORE or RECALL trigger and stays up for exactly `STORE_CYC` or `RECALL_CYC`+1 cycles. The bench changes inputs on the falling clock edge and samples outputs on the next falling edge, so every result is read in its due cycle. Transfer windows are timed by counting the falling edges at which busy is high. During those windows the bench keeps issuing writes and reads, which must be lost.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_RCL_CLR,
    ST_RCL_LOAD,
    ST_IDLE,
    ST_STORE
  } ctl_state_e;

  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_STORE,
    REQ_RECALL
  } xfer_req_e;

endpackage

// File: rtl/nvsram_seqdet.sv
module nvsram_seqdet
  import nvsram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SEQ_A0   = 14,
  parameter int unsigned SEQ_A1   = 49,
  parameter int unsigned SEQ_A2   = 3,
  parameter int unsigned SEQ_A3   = 60,
  parameter int unsigned SEQ_A4   = 48,
  parameter int unsigned STORE_A  = 15,
  parameter int unsigned RECALL_A = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              acc,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] addr,
  output xfer_req_e         req
);

  localparam int unsigned PFX_LEN = 5;
  localparam int unsigned IW      = $clog2(PFX_LEN + 1);
  localparam logic [ADDR_W-1:0] PFX [PFX_LEN] = '{
    ADDR_W'(SEQ_A0), ADDR_W'(SEQ_A1), ADDR_W'(SEQ_A2),
    ADDR_W'(SEQ_A3), ADDR_W'(SEQ_A4)
  };
  localparam logic [ADDR_W-1:0] LAST_ST = ADDR_W'(STORE_A);
  localparam logic [ADDR_W-1:0] LAST_RC = ADDR_W'(RECALL_A);

  logic [IW-1:0]     idx_q, idx_d;
  logic [ADDR_W-1:0] want;
  logic              at_last;
  logic              rd_acc;

  assign at_last = (idx_q == IW'(PFX_LEN));
  assign rd_acc  = idle && acc && acc_rd;

  always_comb begin
    want = PFX[0];
    for (int i = 0; i < int'(PFX_LEN); i++) begin
      if (idx_q == IW'(i)) want = PFX[i];
    end
  end

  always_comb begin
    req = REQ_NONE;
    if (rd_acc && at_last) begin
      if (addr == LAST_ST)      req = REQ_STORE;
      else if (addr == LAST_RC) req = REQ_RECALL;
    end
  end

  always_comb begin
    idx_d = idx_q;
    if (!idle) begin
      idx_d = '0;
    end else if (acc) begin
      if (!acc_rd)                    idx_d = '0;
      else if (!at_last && addr == want) idx_d = idx_q + 1'b1;
      else if (addr == PFX[0])        idx_d = IW'(1);
      else                            idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int unsigned STORE_CYC  = 40,
  parameter int unsigned RECALL_CYC = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      power_ok,
  input  logic      hw_store_n,
  input  xfer_req_e sw_req,
  output logic      idle,
  output logic      start,
  output logic      busy,
  output logic      clear_all,
  output logic      load_all,
  output logic      store_all
);

  localparam int unsigned LONGEST = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int unsigned TW      = $clog2(LONGEST + 1);
  localparam logic [TW-1:0] ST_END = TW'(STORE_CYC - 1);
  localparam logic [TW-1:0] RC_END = TW'(RECALL_CYC - 1);

  ctl_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    st_d      = st_q;
    tmr_d     = '0;
    clear_all = 1'b0;
    load_all  = 1'b0;
    store_all = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        if (power_ok) st_d = ST_RCL_CLR;
      end
      ST_RCL_CLR: begin
        clear_all = 1'b1;
        st_d      = ST_RCL_LOAD;
      end
      ST_RCL_LOAD: begin
        if (tmr_q == RC_END) begin
          load_all = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (!power_ok || !hw_store_n || sw_req == REQ_STORE) st_d = ST_STORE;
        else if (sw_req == REQ_RECALL)                       st_d = ST_RCL_CLR;
      end
      ST_STORE: begin
        if (tmr_q == ST_END) begin
          store_all = 1'b1;
          st_d      = power_ok ? ST_IDLE : ST_OFF;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign idle  = (st_q == ST_IDLE);
  assign start = idle && (st_d != ST_IDLE);
  assign busy  = (st_q == ST_STORE) || (st_q == ST_RCL_CLR) || (st_q == ST_RCL_LOAD);

endmodule

// File: rtl/nvsram_array.sv
module nvsram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              clear_all,
  input  logic              load_all,
  input  logic              store_all
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram_q [DEPTH];
  logic [DATA_W-1:0] nv_q  [DEPTH];

  for (genvar w = 0; w < int'(DEPTH); w++) begin : g_word
    always_ff @(posedge clk) begin
      if (clear_all)                                  ram_q[w] <= '0;
      else if (load_all)                              ram_q[w] <= nv_q[w];
      else if (wr_en && wr_addr == ADDR_W'(w))        ram_q[w] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         nv_q[w] <= '0;
      else if (store_all) nv_q[w] <= ram_q[w];
    end
  end

  assign rd_data = ram_q[rd_addr];

endmodule

// File: rtl/nvsram_top.sv
module nvsram_top
  import nvsram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STORE_CYC  = 40,
  parameter int unsigned RECALL_CYC = 6,
  parameter int unsigned SEQ_A0     = 14,
  parameter int unsigned SEQ_A1     = 49,
  parameter int unsigned SEQ_A2     = 3,
  parameter int unsigned SEQ_A3     = 60,
  parameter int unsigned SEQ_A4     = 48,
  parameter int unsigned STORE_A    = 15,
  parameter int unsigned RECALL_A   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic              power_ok,
  input  logic              hw_store_n,
  output logic              busy_pull_low
);

  xfer_req_e         sw_req;
  logic              ctl_idle, ctl_start, ctl_busy;
  logic              clear_all, load_all, store_all;
  logic              port_act, wr_en, rd_out;
  logic [DATA_W-1:0] rd_data;

  nvsram_seqdet #(
    .ADDR_W(ADDR_W), .SEQ_A0(SEQ_A0), .SEQ_A1(SEQ_A1), .SEQ_A2(SEQ_A2),
    .SEQ_A3(SEQ_A3), .SEQ_A4(SEQ_A4), .STORE_A(STORE_A), .RECALL_A(RECALL_A)
  ) u_seqdet (
    .clk(clk), .rst_n(rst_n), .idle(ctl_idle), .acc(!ce_n), .acc_rd(we_n),
    .addr(addr), .req(sw_req)
  );

  nvsram_ctrl #(
    .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .power_ok(power_ok), .hw_store_n(hw_store_n),
    .sw_req(sw_req), .idle(ctl_idle), .start(ctl_start), .busy(ctl_busy),
    .clear_all(clear_all), .load_all(load_all), .store_all(store_all)
  );

  assign port_act = ctl_idle && !ctl_start;
  assign wr_en    = port_act && !ce_n && !we_n;
  assign rd_out   = port_act && !ce_n && we_n && !oe_n;

  nvsram_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr), .wr_data(dq_in),
    .rd_addr(addr), .rd_data(rd_data), .clear_all(clear_all),
    .load_all(load_all), .store_all(store_all)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe <= rd_out;
      if (rd_out) dq_out <= rd_data;
    end
  end

  assign busy_pull_low = ctl_busy;

endmodule

// File: rtl/nvsram_chk.sv
module nvsram_chk #(
  parameter int unsigned STORE_CYC  = 40,
  parameter int unsigned RECALL_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic power_ok,
  input logic hw_store_n,
  input logic dq_oe,
  input logic busy_pull_low,
  input logic idle
);

  localparam int unsigned MAXRUN = (STORE_CYC > RECALL_CYC + 1) ? STORE_CYC : RECALL_CYC + 1;
  localparam int unsigned CW     = $clog2(MAXRUN + 2);

  logic [CW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             busy_run <= '0;
    else if (!busy_pull_low)                busy_run <= '0;
    else if (busy_run <= CW'(MAXRUN))       busy_run <= busy_run + 1'b1;
  end

  assert_quiet_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_pull_low |-> !dq_oe);

  assert_drive_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_n && we_n && !oe_n));

  assert_hw_store_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !hw_store_n) |=> busy_pull_low);

  assert_power_loss_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !power_ok) |=> busy_pull_low);

  assert_busy_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= CW'(MAXRUN));

endmodule

bind nvsram_top nvsram_chk #(
  .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .power_ok(power_ok), .hw_store_n(hw_store_n), .dq_oe(dq_oe),
  .busy_pull_low(busy_pull_low), .idle(ctl_idle)
);

// File: tb/nvsram_top_bench.sv
`timescale 1ns/1ps
module nvsram_top_bench;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int SC = 40;
  localparam int RC = 6;
  localparam logic [AW-1:0] PFX [5] = '{6'd14, 6'd49, 6'd3, 6'd60, 6'd48};
  localparam logic [AW-1:0] ST_A = 6'd15;
  localparam logic [AW-1:0] RC_A = 6'd12;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, power_ok, hw_ext_n;
  logic [AW-1:0] addr;
  logic [7:0] dq_in, dq_out;
  logic dq_oe, busy_pull_low, hw_store_n;

  assign hw_store_n = hw_ext_n & ~busy_pull_low;

  always #2.5 clk = ~clk;

  nvsram_top u_nvsram_top (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .power_ok(power_ok), .hw_store_n(hw_store_n), .busy_pull_low(busy_pull_low)
  );

  logic [7:0] m_ram [DEPTH];
  logic [7:0] m_nv  [DEPTH];
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rd_word(input bit oe, input logic [7:0] d);
    return {23'd0, oe, d};
  endfunction

  task automatic op(input bit c, input bit w, input bit o, input logic [AW-1:0] a, input logic [7:0] d);
    ce_n = c; we_n = w; oe_n = o; addr = a; dq_in = d;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    op(1'b0, 1'b1, 1'b0, a, 8'h00);
    chk(dq_oe === 1'b1 && dq_out === m_ram[a], req, rd_word(dq_oe, dq_out), rd_word(1'b1, m_ram[a]));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit o);
    op(1'b0, 1'b0, o, a, d);
    m_ram[a] = d;
    chk(dq_oe === 1'b0, "R2 no drive after write", int'(dq_oe), 0);
  endtask

  task automatic wait_busy(input int exp_len, input string req);
    int cnt = 0;
    while (busy_pull_low === 1'b1 && cnt < 1000) begin
      ce_n = 1'b0; we_n = 1'($urandom % 2); oe_n = 1'b0;
      addr = AW'($urandom); dq_in = 8'($urandom);
      @(negedge clk);
      cnt++;
      chk(dq_oe === 1'b0, "R5 quiet while busy", int'(dq_oe), 0);
    end
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    chk(cnt == exp_len, req, cnt, exp_len);
  endtask

  task automatic do_store_model();
    for (int i = 0; i < DEPTH; i++) m_nv[i] = m_ram[i];
  endtask

  task automatic do_recall_model();
    for (int i = 0; i < DEPTH; i++) m_ram[i] = m_nv[i];
  endtask

  task automatic verify_all(input string req);
    for (int i = 0; i < DEPTH; i++) rd_chk(AW'(i), req);
  endtask

  task automatic hw_store();
    op(1'b1, 1'b1, 1'b1, '0, '0);
    hw_ext_n = 1'b0;
    @(negedge clk);
    hw_ext_n = 1'b1;
    chk(busy_pull_low === 1'b1, "R4 busy after store request", int'(busy_pull_low), 1);
    wait_busy(SC, "R4 store length");
    do_store_model();
  endtask

  task automatic sw_seq(input logic [AW-1:0] last, input bit gaps);
    for (int i = 0; i < 5; i++) begin
      rd_chk(PFX[i], "R6 prefix read data");
      if (gaps) op(1'b1, 1'b1, 1'b1, AW'($urandom), 8'h00);
    end
    op(1'b0, 1'b1, 1'b0, last, 8'h00);
    chk(dq_oe === 1'b0 && busy_pull_low === 1'b1, "R6 final read starts transfer",
        {dq_oe, busy_pull_low}, 1);
    if (last == ST_A) begin
      wait_busy(SC, "R6 sw store length");
      do_store_model();
    end else begin
      wait_busy(RC + 1, "R8 recall length");
      do_recall_model();
    end
  endtask

  initial begin
    ce_n = 1; we_n = 1; oe_n = 1; addr = '0; dq_in = '0;
    power_ok = 0; hw_ext_n = 1; rst_n = 0;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin m_ram[i] = 8'h00; m_nv[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(dq_oe === 1'b0, "R10 reset dq_oe", int'(dq_oe), 0);
    chk(busy_pull_low === 1'b0, "R10 reset busy", int'(busy_pull_low), 0);
    rst_n = 1;
    @(negedge clk);
    op(1'b0, 1'b1, 1'b0, 6'd5, 8'h00);
    chk(dq_oe === 1'b0, "R10 port off before power", int'(dq_oe), 0);
    op(1'b1, 1'b1, 1'b1, '0, '0);
    power_ok = 1;
    @(negedge clk);
    chk(busy_pull_low === 1'b1, "R10 power-up recall starts", int'(busy_pull_low), 1);
    wait_busy(RC + 1, "R8 power-up recall length");
    do_recall_model();
    for (int i = 0; i < 8; i++) rd_chk(AW'(i * 9), "R10 blank after reset");

    wr(6'd1, 8'hA5, 1'b0);
    wr(6'd2, 8'h5A, 1'b1);
    rd_chk(6'd1, "R1 read back");
    rd_chk(6'd2, "R2 write with oe high");
    op(1'b0, 1'b1, 1'b1, 6'd1, 8'h00);
    chk(dq_oe === 1'b0, "R3 internal read no drive", int'(dq_oe), 0);
    op(1'b1, 1'b0, 1'b0, 6'd1, 8'hFF);
    chk(dq_oe === 1'b0, "R3 standby no drive", int'(dq_oe), 0);
    rd_chk(6'd1, "R3 standby write ignored");

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a = AW'($urandom);
      if ($urandom % 2) wr(a, 8'($urandom), 1'($urandom % 2));
      else rd_chk(a, "R1 random read");
    end
    verify_all("R1 full scan");

    hw_store();
    verify_all("R4 sram kept after store");
    for (int i = 0; i < 10; i++) wr(AW'(i * 5), 8'($urandom), 1'b1);
    sw_seq(RC_A, 1'b0);
    verify_all("R11 recall restores stored data");
    for (int i = 0; i < 6; i++) wr(AW'(i * 7), 8'($urandom), 1'b0);
    sw_seq(RC_A, 1'b1);
    verify_all("R8 repeat recall same data");

    for (int i = 0; i < 12; i++) wr(AW'(i * 3 + 1), 8'($urandom), 1'b1);
    sw_seq(ST_A, 1'b1);
    for (int i = 0; i < 4; i++) wr(AW'(i), 8'($urandom), 1'b0);
    sw_seq(RC_A, 1'b0);
    verify_all("R6 sw store then recall");

    wr(6'd20, 8'h77, 1'b1);
    rd_chk(PFX[0], "R7 abort chain");
    rd_chk(PFX[1], "R7 abort chain");
    rd_chk(PFX[2], "R7 abort chain");
    wr(6'd21, 8'h88, 1'b1);
    rd_chk(PFX[3], "R7 abort chain");
    rd_chk(PFX[4], "R7 abort chain");
    rd_chk(ST_A, "R7 write breaks chain");
    chk(busy_pull_low === 1'b0, "R7 no store after write", int'(busy_pull_low), 0);
    rd_chk(PFX[0], "R7 abort chain");
    rd_chk(PFX[1], "R7 abort chain");
    rd_chk(6'd5, "R7 abort chain");
    rd_chk(PFX[2], "R7 abort chain");
    rd_chk(PFX[3], "R7 abort chain");
    rd_chk(PFX[4], "R7 abort chain");
    rd_chk(ST_A, "R7 stray read breaks chain");
    chk(busy_pull_low === 1'b0, "R7 no store after stray read", int'(busy_pull_low), 0);
    sw_seq(RC_A, 1'b0);
    verify_all("R7 shadow untouched by aborted chains");

    for (int i = 0; i < 8; i++) wr(AW'(i * 8 + 2), 8'($urandom), 1'b1);
    for (int i = 0; i < 5; i++) rd_chk(PFX[i], "R12 prefix");
    hw_ext_n = 1'b0;
    op(1'b0, 1'b1, 1'b0, RC_A, 8'h00);
    hw_ext_n = 1'b1;
    chk(busy_pull_low === 1'b1, "R12 busy on coincident requests", int'(busy_pull_low), 1);
    wait_busy(SC, "R12 hw store wins over recall");
    do_store_model();
    for (int i = 0; i < 3; i++) wr(AW'(i * 8 + 2), 8'($urandom), 1'b0);
    sw_seq(RC_A, 1'b0);
    verify_all("R12 stored data came from store");

    for (int i = 0; i < 9; i++) wr(AW'(i * 6 + 3), 8'($urandom), 1'b1);
    op(1'b1, 1'b1, 1'b1, '0, '0);
    power_ok = 0;
    @(negedge clk);
    chk(busy_pull_low === 1'b1, "R9 power loss store starts", int'(busy_pull_low), 1);
    wait_busy(SC, "R9 power loss store length");
    do_store_model();
    for (int i = 0; i < 5; i++) begin
      op(1'b0, 1'b1, 1'b0, AW'(i), 8'h00);
      chk(dq_oe === 1'b0 && busy_pull_low === 1'b0, "R9 port off without power",
          {dq_oe, busy_pull_low}, 0);
      op(1'b0, 1'b0, 1'b0, AW'(i), 8'hEE);
    end
    op(1'b1, 1'b1, 1'b1, '0, '0);
    power_ok = 1;
    @(negedge clk);
    chk(busy_pull_low === 1'b1, "R9 power-up recall starts", int'(busy_pull_low), 1);
    wait_busy(RC + 1, "R9 power-up recall length");
    do_recall_model();
    verify_all("R9 data kept over power cycle");

    done = 1;
    report();
  end

endmodule